// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Access Permissions

This block maps 32-bit virtual addresses onto physical addresses in 4 KB pages for a processor core whose operating system owns the page table. It holds a small, fully associative set of translations. Each translation is tagged with an 8-bit process identifier, or marked global so that every process shares it. The block does not walk a page table on its own. A lookup that finds no translation is reported as a miss, and software then installs the missing entry through a dedicated write port.

Each lookup presents a virtual address, the current process identifier and the kind of access (load, store or instruction fetch). One clock later the block returns a physical address built from the stored frame number and the untranslated page offset. It also returns a hit flag, a flag that is raised when the entry forbids the requested kind of access, the page's cacheable attribute, and a flag that shows when more than one entry matched. A one-cycle invalidate input flushes every translation, for example on an address-space switch.

Top module: `sw_tlb`

## Requirements
- R1: After reset, `rs_valid` and `rs_hit` are 0 and every entry is invalid, so a lookup of VA 0 with PID 0 misses.
- R2: A lookup accepted with `lk_req`=1 at a clock edge produces its result at that edge: `rs_valid` is 1 for that one cycle and 0 in any cycle that follows an edge without a request.
- R3: A lookup hits only when a valid entry's page number equals `lk_vaddr[31:12]` and either its PID equals `lk_pid` or its global bit is set. An entry written with valid=0 never hits.
- R4: On a hit, `rs_paddr` = {frame number, `lk_vaddr[11:0]`}. The low 12 bits are copied unchanged.
- R5: On a hit, `rs_fault` is 1 when the requested access is not permitted. The encodings are: `lk_acc`=0 (read) tests the read bit, 1 (write) tests the write bit, 2 (fetch) tests the execute bit, and 3 is always a fault. `rs_fault` is never 1 without `rs_hit`.
- R6: On a hit, `rs_cacheable` equals the entry's cacheable bit. On a miss, `rs_paddr`, `rs_cacheable`, `rs_fault` and `rs_multi` are all 0.
- R7: A write to an entry takes effect at the clock edge that samples `wr_en`. A lookup sampled at that same edge sees the entry's previous contents.
- R8: When several entries match, the lowest-indexed one supplies the result and `rs_multi` is 1. When exactly one entry matches, `rs_multi` is 0.
- R9: `inv_all`=1 clears every valid bit at the next edge. A write in that same cycle is discarded, so its entry stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | 8 | Current process identifier |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry slot to write |
| wr_vpn | input | 20 | Virtual page number for the entry |
| wr_pid | input | 8 | Process identifier for the entry |
| wr_global | input | 1 | Entry matches any process |
| wr_pfn | input | 20 | Physical frame number for the entry |
| wr_perm_r | input | 1 | Read allowed |
| wr_perm_w | input | 1 | Write allowed |
| wr_perm_x | input | 1 | Execute allowed |
| wr_cache | input | 1 | Page is cacheable |
| wr_valid | input | 1 | Entry valid bit |
| inv_all | input | 1 | Invalidate every entry |
| rs_valid | output | 1 | Result present this cycle |
| rs_hit | output | 1 | Translation found |
| rs_paddr | output | 32 | Physical address (0 on miss) |
| rs_fault | output | 1 | Permission violation on a hit |
| rs_cacheable | output | 1 | Cacheable attribute of the hit page |
| rs_multi | output | 1 | More than one entry matched |

## Verification
The bench first reuses a page number under a second process identifier. A design that ignored the PID tag would hit there, and one that ignored the global bit would miss on the shared page. Each of the four access kinds is then tried against a single entry with mixed permissions. This exposes a design that tests the wrong permission bit or lets the reserved code through. Two entries are made to match at once, and one of them sits at a higher slot, so a picker that chose the highest slot, or a multi-hit flag that missed the overlap, returns the wrong frame. The bench also overwrites an entry while looking it up in the same cycle, and issues a flush together with a write. A store that bypassed its new value to the lookup, or that let the write win over the flush, would report the new frame too early or leave a stale hit.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W  = 32;
  localparam int unsigned OFF_W = 12;
  localparam int unsigned VPN_W = VA_W - OFF_W;
  localparam int unsigned PFN_W = 20;
  localparam int unsigned PA_W  = PFN_W + OFF_W;
  localparam int unsigned PID_W = 8;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef struct packed {
    logic             valid;
    logic             glob;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;
    logic             pr;
    logic             pw;
    logic             px;
    logic             cache;
  } tlb_ent_t;

  // Tag compare for one entry
  function automatic logic ent_match(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                     logic [PID_W-1:0] pid);
    return e.valid && (e.vpn == vpn) && (e.glob || (e.pid == pid));
  endfunction

  // Permission test for the requested access kind
  function automatic logic perm_ok(tlb_ent_t e, acc_e a);
    case (a)
      ACC_RD:  return e.pr;
      ACC_WR:  return e.pw;
      ACC_EX:  return e.px;
      default: return 1'b0;
    endcase
  endfunction

  // Physical address assembly: frame above untouched offset
  function automatic logic [PA_W-1:0] join_pa(logic [PFN_W-1:0] pfn,
                                              logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  tlb_ent_t               wr_ent,
  input  logic                   inv_all,
  output tlb_ent_t [N_ENT-1:0]   ents
);
  logic [N_ENT-1:0] vld_vec;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    tlb_ent_t ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (inv_all)
        ent_q.valid <= 1'b0;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        ent_q <= wr_ent;
    end
    assign ents[i]    = ent_q;
    assign vld_vec[i] = ent_q.valid;
  end

  // R9: flush leaves nothing valid
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_vec == '0));

  // R7: write lands at the next edge
  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all) |=> (ents[$past(wr_idx)] == $past(wr_ent)));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  tlb_ent_t [N_ENT-1:0] ents,
  input  logic [VPN_W-1:0]     vpn,
  input  logic [PID_W-1:0]     pid,
  output logic [N_ENT-1:0]     hit_vec
);
  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign hit_vec[i] = ent_match(ents[i], vpn, pid);
  end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ENT-1:0] hit_vec,
  output logic [IDX_W-1:0] sel_idx,
  output logic [N_ENT-1:0] sel_oh,
  output logic             any,
  output logic             multi
);
  always_comb begin
    sel_idx = '0;
    sel_oh  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel_idx = IDX_W'(i);
        sel_oh  = '0;
        sel_oh[i] = 1'b1;
      end
    end
  end

  assign any   = |hit_vec;
  assign multi = |(hit_vec & (hit_vec - 1'b1));

  // R8: one winner, drawn from the matches, with no lower match
  a_r8_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh) && (any == (sel_oh != '0)));
  a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_oh & hit_vec) == sel_oh) && (((sel_oh - 1'b1) & hit_vec) == '0));
  a_r8_multi_count: assert property (@(posedge clk) disable iff (!rst_n)
    multi == ($countones(hit_vec) > 1));
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [31:0]       lk_vaddr,
  input  logic [7:0]        lk_pid,
  input  logic [1:0]        lk_acc,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [19:0]       wr_vpn,
  input  logic [7:0]        wr_pid,
  input  logic              wr_global,
  input  logic [19:0]       wr_pfn,
  input  logic              wr_perm_r,
  input  logic              wr_perm_w,
  input  logic              wr_perm_x,
  input  logic              wr_cache,
  input  logic              wr_valid,
  input  logic              inv_all,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [31:0]       rs_paddr,
  output logic              rs_fault,
  output logic              rs_cacheable,
  output logic              rs_multi
);
  tlb_ent_t [N_ENT-1:0] ents;
  tlb_ent_t             wr_ent;
  logic [N_ENT-1:0]     hit_vec;
  logic [N_ENT-1:0]     sel_oh;
  logic [IDX_W-1:0]     sel_idx;
  logic                 lk_any;
  logic                 lk_multi;
  tlb_ent_t             sel_ent;
  logic                 lk_hit_now;
  logic                 lk_fault_now;
  logic [VPN_W-1:0]     lk_vpn;
  logic [OFF_W-1:0]     lk_off;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
  assign lk_off = lk_vaddr[OFF_W-1:0];

  always_comb begin
    wr_ent       = '0;
    wr_ent.valid = wr_valid;
    wr_ent.glob  = wr_global;
    wr_ent.vpn   = wr_vpn;
    wr_ent.pid   = wr_pid;
    wr_ent.pfn   = wr_pfn;
    wr_ent.pr    = wr_perm_r;
    wr_ent.pw    = wr_perm_w;
    wr_ent.px    = wr_perm_x;
    wr_ent.cache = wr_cache;
  end

  tlb_entry_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_ent(wr_ent), .inv_all(inv_all), .ents(ents)
  );

  tlb_match #(.N_ENT(N_ENT)) u_match (
    .ents(ents), .vpn(lk_vpn), .pid(lk_pid), .hit_vec(hit_vec)
  );

  tlb_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .sel_idx(sel_idx),
    .sel_oh(sel_oh), .any(lk_any), .multi(lk_multi)
  );

  assign sel_ent      = ents[sel_idx];
  assign lk_hit_now   = lk_req && lk_any;
  assign lk_fault_now = lk_hit_now && !perm_ok(sel_ent, acc_e'(lk_acc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid     <= 1'b0;
      rs_hit       <= 1'b0;
      rs_paddr     <= '0;
      rs_fault     <= 1'b0;
      rs_cacheable <= 1'b0;
      rs_multi     <= 1'b0;
    end else begin
      rs_valid     <= lk_req;
      rs_hit       <= lk_hit_now;
      rs_paddr     <= lk_hit_now ? join_pa(sel_ent.pfn, lk_off) : '0;
      rs_fault     <= lk_fault_now;
      rs_cacheable <= lk_hit_now && sel_ent.cache;
      rs_multi     <= lk_hit_now && lk_multi;
    end
  end

  // R2: result exactly one cycle after the request
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rs_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rs_valid);
  // R4: offset copied unchanged
  a_r4_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_any) |=> (rs_paddr[OFF_W-1:0] == $past(lk_off)));
  // R5: a fault needs a hit
  a_r5_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rs_fault |-> rs_hit);
  // R6: quiet outputs on a miss
  a_r6_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_hit |-> (rs_paddr == '0 && !rs_cacheable && !rs_multi));
  // R8: multi-hit only with a hit
  a_r8_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rs_multi |-> rs_hit);
endmodule

// File: tb/test_sw_tlb.sv
module test_sw_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_pid = '0;
  logic [1:0]  lk_acc = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [19:0] wr_vpn = '0;
  logic [7:0]  wr_pid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_pfn = '0;
  logic        wr_perm_r = 1'b0, wr_perm_w = 1'b0, wr_perm_x = 1'b0;
  logic        wr_cache = 1'b0, wr_valid = 1'b0, inv_all = 1'b0;
  logic        rs_valid, rs_hit, rs_fault, rs_cacheable, rs_multi;
  logic [31:0] rs_paddr;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  sw_tlb i_sw_tlb (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_pid(lk_pid), .lk_acc(lk_acc), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_vpn(wr_vpn), .wr_pid(wr_pid), .wr_global(wr_global),
    .wr_pfn(wr_pfn), .wr_perm_r(wr_perm_r), .wr_perm_w(wr_perm_w),
    .wr_perm_x(wr_perm_x), .wr_cache(wr_cache), .wr_valid(wr_valid),
    .inv_all(inv_all), .rs_valid(rs_valid), .rs_hit(rs_hit),
    .rs_paddr(rs_paddr), .rs_fault(rs_fault),
    .rs_cacheable(rs_cacheable), .rs_multi(rs_multi)
  );

  task automatic check(input string tag, input logic [63:0] got,
                       input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic set_wr(input logic [3:0] idx, input logic [19:0] vpn,
                        input logic [7:0] pid, input logic g,
                        input logic [19:0] pfn, input logic r, input logic w,
                        input logic x, input logic c, input logic v);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_pid = pid; wr_global = g;
    wr_pfn = pfn; wr_perm_r = r; wr_perm_w = w; wr_perm_x = x;
    wr_cache = c; wr_valid = v;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [19:0] vpn,
                          input logic [7:0] pid, input logic g,
                          input logic [19:0] pfn, input logic r, input logic w,
                          input logic x, input logic c, input logic v);
    @(negedge clk);
    set_wr(idx, vpn, pid, g, pfn, r, w, x, c, v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Result is registered at the edge between the two negedges
  task automatic do_lookup(input logic [31:0] va, input logic [7:0] pid,
                           input logic [1:0] acc);
    @(negedge clk);
    lk_req = 1'b1; lk_vaddr = va; lk_pid = pid; lk_acc = acc;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rs_valid in reset", rs_valid, 0);
    check("R1 rs_hit in reset", rs_hit, 0);
    rst_n = 1'b1;
    do_lookup(32'h0, 8'h00, 2'd0);
    check("R1 lookup after reset misses", rs_hit, 0);
  endtask

  task automatic t_basic;
    do_write(4'd3, 20'h12345, 8'h21, 1'b0, 20'hABCDE, 1, 0, 1, 1, 1);
    do_lookup(32'h123456F0, 8'h21, 2'd0);
    check("R2 rs_valid on result cycle", rs_valid, 1);
    check("R3 hit on exact tag", rs_hit, 1);
    check("R4 paddr", rs_paddr, 32'hABCDE6F0);
    check("R5 read allowed", rs_fault, 0);
    check("R6 cacheable", rs_cacheable, 1);
    check("R8 single match no multi", rs_multi, 0);
    @(negedge clk);
    check("R2 rs_valid drops", rs_valid, 0);
    do_lookup(32'h12345001, 8'h21, 2'd1);
    check("R5 write denied", rs_fault, 1);
    check("R5 write denied still hit", rs_hit, 1);
    do_lookup(32'h12345FFF, 8'h21, 2'd2);
    check("R5 fetch allowed", rs_fault, 0);
    check("R4 offset all ones", rs_paddr, 32'hABCDEFFF);
    do_lookup(32'h12345000, 8'h21, 2'd3);
    check("R5 reserved access faults", rs_fault, 1);
  endtask

  task automatic t_pid;
    do_lookup(32'h12345010, 8'h22, 2'd0);
    check("R3 other pid misses", rs_hit, 0);
    check("R6 miss paddr zero", rs_paddr, 0);
    check("R6 miss no fault", rs_fault, 0);
    check("R6 miss not cacheable", rs_cacheable, 0);
    do_write(4'd5, 20'h00077, 8'h01, 1'b1, 20'h11111, 1, 1, 0, 0, 1);
    do_lookup(32'h00077ABC, 8'h99, 2'd1);
    check("R3 global ignores pid", rs_hit, 1);
    check("R4 global paddr", rs_paddr, 32'h11111ABC);
    check("R6 uncacheable page", rs_cacheable, 0);
    do_lookup(32'h00077ABC, 8'h99, 2'd2);
    check("R5 exec denied", rs_fault, 1);
    do_write(4'd6, 20'h55555, 8'h40, 1'b0, 20'h66666, 1, 1, 1, 1, 0);
    do_lookup(32'h55555000, 8'h40, 2'd0);
    check("R3 invalid entry misses", rs_hit, 0);
  endtask

  task automatic t_multi;
    do_write(4'd9, 20'h0AAAA, 8'h30, 1'b0, 20'h22222, 1, 0, 0, 0, 1);
    do_lookup(32'h0AAAA004, 8'h30, 2'd0);
    check("R8 lone match paddr", rs_paddr, 32'h22222004);
    check("R8 lone match no multi", rs_multi, 0);
    do_write(4'd2, 20'h0AAAA, 8'h00, 1'b1, 20'h33333, 1, 1, 1, 1, 1);
    do_lookup(32'h0AAAA004, 8'h30, 2'd1);
    check("R8 lowest index wins", rs_paddr, 32'h33333004);
    check("R8 multi flag", rs_multi, 1);
    check("R8 winner permissions", rs_fault, 0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    set_wr(4'd3, 20'h12345, 8'h21, 1'b0, 20'h44444, 1, 1, 1, 0, 1);
    lk_req = 1'b1; lk_vaddr = 32'h12345100; lk_pid = 8'h21; lk_acc = 2'd0;
    @(negedge clk);
    wr_en = 1'b0; lk_req = 1'b0;
    check("R7 same-cycle lookup sees old", rs_paddr, 32'hABCDE100);
    do_lookup(32'h12345100, 8'h21, 2'd1);
    check("R7 next lookup sees new", rs_paddr, 32'h44444100);
    check("R7 new permissions", rs_fault, 0);
  endtask

  task automatic t_flush;
    @(negedge clk);
    set_wr(4'd7, 20'h07070, 8'h05, 1'b0, 20'h77777, 1, 1, 1, 1, 1);
    inv_all = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; inv_all = 1'b0;
    do_lookup(32'h07070000, 8'h05, 2'd0);
    check("R9 write during flush dropped", rs_hit, 0);
    do_lookup(32'h12345100, 8'h21, 2'd0);
    check("R9 old entry flushed", rs_hit, 0);
    do_lookup(32'h00077000, 8'h01, 2'd0);
    check("R9 global entry flushed", rs_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_pid();
    t_multi();
    t_same_cycle();
    t_flush();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule